// File: doc/BRIEF.md
# Audio Master Clock Ratio Divider

This block produces the master clock that an external audio converter needs. It derives that clock from a fast on-chip clock by a power-of-two divide. The fast clock runs at twice the serial-port base rate. That base rate is either 512 or 384 times the sample rate (fs), selected by one input bit. A 3-bit shift code picks the divide. Each legal code gives one standard oversampling ratio: 512, 256, 128, 64 or 32 times fs on the 512 base, and 384, 192, 96 or 48 times fs on the 384 base.

The output is a registered square wave with a 50% duty cycle. It runs only while the run input is high, the gate input is low and the code is legal. A code written during operation is adopted only at a period boundary. A stop request never shortens a high half. An illegal code keeps the clock low and raises an error flag. All of this keeps runt pulses off the converter clock pin.

Top module: `mclk_ratio_div`

## Requirements
- R1: While reset is asserted and until a legal start, `mclk`, `mclk_en` and `rate_err` are all low.
- R2: With `base_sel`=0 (512fs base) and `rate_code`=k for k from 0 to 4, `mclk` has a period of 2^(k+1) fast clock cycles. Each period is 2^k cycles low followed by 2^k cycles high.
- R3: With `base_sel`=1 (384fs base) and `rate_code`=k for k from 0 to 3, `mclk` has the same period and phase shape as in R2.
- R4: Starting needs `run`=1, `gate`=0 and a legal code all sampled at one clock edge. `mclk_en` is then high from that edge on, and `mclk` begins with its low half.
- R5: Codes 5, 6 and 7 on either base, and code 4 with `base_sel`=1, are illegal. With an illegal code the divider does not start and `mclk` stays low. `rate_err` is high from the edge after the illegal code is presented, and low from the edge after a legal code is presented.
- R6: While `gate`=1 the divider does not start, even with `run`=1, and `mclk` stays low.
- R7: A new `rate_code` presented during operation is taken only when a high half ends. Until then the running period keeps its old ratio. The next period starts low with the new ratio.
- R8: When the start condition is removed during a high half, that high half completes. Then `mclk` and `mclk_en` both go low at the same edge.
- R9: When the start condition is removed during a low half, `mclk_en` falls at the next edge and `mclk` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the serial-port base rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| base_sel | input | 1 | Base rate select: 0 = 512fs, 1 = 384fs |
| rate_code | input | 3 | Power-of-two divide shift code |
| run | input | 1 | Request to run the master clock |
| gate | input | 1 | Clock gate; 1 blocks the master clock |
| mclk | output | 1 | Divided master clock to the converter |
| mclk_en | output | 1 | High while the divider is running |
| rate_err | output | 1 | High while the presented code is illegal for the base |

## Verification
A wrong counter or phase state shows on `mclk` within one period as a high or low half of the wrong length. A latched code that changes too early shows as a shortened period before the boundary. A faulty stop decision shows within one half period: `mclk_en` falls too early or too late, or `mclk` has a runt high. The bench compares `mclk`, `mclk_en` and `rate_err` against an expected trace on every cycle. Every such fault therefore surfaces at the first cycle where the trace diverges.

// File: rtl/mclk_div_pkg.sv
package mclk_div_pkg;

  typedef enum logic {
    BASE_512 = 1'b0,
    BASE_384 = 1'b1
  } mclk_base_e;

  // Counter needs one bit more than the largest shift to hold both halves.
  function automatic int unsigned div_cnt_width(input int unsigned shift_max);
    return shift_max + 1;
  endfunction

endpackage

// File: rtl/mclk_code_decode.sv
module mclk_code_decode
  import mclk_div_pkg::*;
#(
  parameter int unsigned SHIFT_MAX = 4,
  parameter int unsigned CODE_W    = 3
) (
  input  logic              base_sel,
  input  logic [CODE_W-1:0] code,
  output logic              code_ok
);

  localparam logic [CODE_W-1:0] LIM_512 = CODE_W'(SHIFT_MAX);
  localparam logic [CODE_W-1:0] LIM_384 = CODE_W'(SHIFT_MAX - 1);

  mclk_base_e base;

  always_comb begin
    base = mclk_base_e'(base_sel);
    if (base == BASE_384) code_ok = (code <= LIM_384);
    else                  code_ok = (code <= LIM_512);
  end

endmodule

// File: rtl/mclk_div_core.sv
module mclk_div_core
  import mclk_div_pkg::*;
#(
  parameter int unsigned SHIFT_MAX = 4,
  parameter int unsigned CODE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              gate,
  input  logic              code_ok,
  input  logic [CODE_W-1:0] code_in,
  output logic              mclk,
  output logic              active
);

  localparam int unsigned CNT_W = div_cnt_width(SHIFT_MAX);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  sel_vec, mask_vec;
  logic [CODE_W-1:0] code_q, code_d;
  logic              active_q, active_d;
  logic              mclk_q, mclk_d;
  logic              phase_hi, wrap, go, upd_en;

  // Per-bit select of the phase bit and of the bits that form one period.
  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_bits
    assign sel_vec[gi]  = (code_q == CODE_W'(gi));
    assign mask_vec[gi] = (CODE_W'(gi) <= code_q);
  end

  assign phase_hi = |(cnt_q & sel_vec);
  assign wrap     = &(cnt_q | ~mask_vec);
  assign go       = run & ~gate & code_ok;
  assign upd_en   = active_q | go;

  always_comb begin
    cnt_d    = cnt_q;
    code_d   = code_q;
    active_d = active_q;
    if (!active_q) begin
      cnt_d = '0;
      if (go) begin
        active_d = 1'b1;
        code_d   = code_in;
      end
    end else if (!go && !phase_hi) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (wrap) begin
      cnt_d = '0;
      if (go) code_d = code_in;
      else    active_d = 1'b0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    // Code only changes together with a counter restart, so sel_vec still applies.
    mclk_d = active_d & |(cnt_d & sel_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      code_q   <= '0;
      active_q <= 1'b0;
      mclk_q   <= 1'b0;
    end else if (upd_en) begin
      cnt_q    <= cnt_d;
      code_q   <= code_d;
      active_q <= active_d;
      mclk_q   <= mclk_d;
    end
  end

  assign mclk   = mclk_q;
  assign active = active_q;

  AST_HIGH_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && phase_hi && !wrap) |=> mclk_q); // R8

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !wrap) |=> (code_q == $past(code_q))); // R7

  AST_NO_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && gate) |=> !active_q); // R6

  AST_NO_START_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !code_ok) |=> (!active_q && !mclk_q)); // R5

  AST_LOW_STOP_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !phase_hi && !go) |=> (!active_q && !mclk_q)); // R9

endmodule

// File: rtl/mclk_ratio_div.sv
module mclk_ratio_div
  import mclk_div_pkg::*;
#(
  parameter int unsigned SHIFT_MAX = 4,
  parameter int unsigned CODE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_sel,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              run,
  input  logic              gate,
  output logic              mclk,
  output logic              mclk_en,
  output logic              rate_err
);

  logic rst_meta_q, rst_sync_q;
  logic code_ok;
  logic err_q, err_d;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mclk_code_decode #(
    .SHIFT_MAX (SHIFT_MAX),
    .CODE_W    (CODE_W)
  ) u_decode (
    .base_sel (base_sel),
    .code     (rate_code),
    .code_ok  (code_ok)
  );

  mclk_div_core #(
    .SHIFT_MAX (SHIFT_MAX),
    .CODE_W    (CODE_W)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .run     (run),
    .gate    (gate),
    .code_ok (code_ok),
    .code_in (rate_code),
    .mclk    (mclk),
    .active  (mclk_en)
  );

  always_comb err_d = ~code_ok;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign rate_err = err_q;

  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !code_ok |=> rate_err); // R5

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_q)
    code_ok |=> !rate_err); // R5

endmodule

// File: tb/tb_mclk_ratio_div.sv
module tb_mclk_ratio_div;

  logic       clk;
  logic       rst_n;
  logic       base_sel;
  logic [2:0] rate_code;
  logic       run;
  logic       gate;
  logic       mclk;
  logic       mclk_en;
  logic       rate_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] mon_exp;
  logic [2:0] mon_act;
  string      mon_tag;

  mclk_ratio_div dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_sel  (base_sel),
    .rate_code (rate_code),
    .run       (run),
    .gate      (gate),
    .mclk      (mclk),
    .mclk_en   (mclk_en),
    .rate_err  (rate_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic check_now(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual {mclk,en,err}=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // Item order: {mclk, mclk_en, rate_err}
  task automatic push_exp(input logic [2:0] v, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
    end
  endtask

  task automatic wait_drain();
    do @(negedge clk); while (exp_q.size() != 0);
  endtask

  task automatic stop_and_idle(input string tag);
    run = 1'b0;
    push_exp(3'b000, 3, tag);
    wait_drain();
  endtask

  task automatic run_code(input bit base, input int code, input int periods, input string tag);
    int h;
    h = 1 << code;
    @(negedge clk);
    base_sel  = base;
    rate_code = 3'(code);
    gate      = 1'b0;
    run       = 1'b1;
    for (int p = 0; p < periods; p++) begin
      push_exp(3'b010, h, tag);
      push_exp(3'b110, h, tag);
    end
    wait_drain();
    stop_and_idle(tag);
  endtask

  // Monitor: compares one expected item per cycle, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        mon_act = {mclk, mclk_en, rate_err};
        check_now(mon_act, mon_exp, mon_tag);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  initial begin
    rst_n = 1'b0; base_sel = 1'b0; rate_code = 3'd0; run = 1'b0; gate = 1'b0;
    repeat (3) @(negedge clk);
    check_now({mclk, mclk_en, rate_err}, 3'b000, "R1 in reset");
    run = 1'b1;
    @(negedge clk);
    check_now({mclk, mclk_en, rate_err}, 3'b000, "R1 in reset with run");
    run = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    push_exp(3'b000, 3, "R1 after reset");
    wait_drain();

    // R2: 512fs base, every legal shift
    for (int k = 0; k <= 4; k++) run_code(1'b0, k, 2, $sformatf("R2 code %0d", k));
    // R3: 384fs base, every legal shift
    for (int k = 0; k <= 3; k++) run_code(1'b1, k, 2, $sformatf("R3 code %0d", k));
    // R4: a single period from idle starts with its low half
    run_code(1'b0, 1, 1, "R4 start phase");

    // R5: illegal codes
    @(negedge clk);
    base_sel = 1'b1; rate_code = 3'd4; run = 1'b1; gate = 1'b0;
    push_exp(3'b001, 3, "R5 code 4 on 384 base");
    wait_drain();
    base_sel = 1'b0; rate_code = 3'd5;
    push_exp(3'b001, 2, "R5 code 5");
    wait_drain();
    rate_code = 3'd7; base_sel = 1'b1;
    push_exp(3'b001, 2, "R5 code 7");
    wait_drain();
    rate_code = 3'd1; run = 1'b0;
    push_exp(3'b000, 2, "R5 error clears");
    wait_drain();

    // R6: gate blocks start
    base_sel = 1'b0; rate_code = 3'd1; run = 1'b1; gate = 1'b1;
    push_exp(3'b000, 4, "R6 gated");
    wait_drain();
    run = 1'b0; gate = 1'b0;

    // R7: code change mid-period adopted at the boundary
    @(negedge clk);
    base_sel = 1'b0; rate_code = 3'd2; run = 1'b1;
    push_exp(3'b010, 4, "R7 old ratio");
    push_exp(3'b110, 4, "R7 old ratio");
    for (int p = 0; p < 2; p++) begin
      push_exp(3'b010, 1, "R7 new ratio");
      push_exp(3'b110, 1, "R7 new ratio");
    end
    do @(negedge clk); while (exp_q.size() > 10);
    rate_code = 3'd0;
    wait_drain();
    stop_and_idle("R7 stop");

    // R9: stop request inside a low half
    @(negedge clk);
    rate_code = 3'd2; run = 1'b1;
    push_exp(3'b010, 2, "R9 running");
    wait_drain();
    stop_and_idle("R9 stop from low");

    // R8: stop request inside a high half
    @(negedge clk);
    rate_code = 3'd2; run = 1'b1;
    push_exp(3'b010, 4, "R8 running");
    push_exp(3'b110, 2, "R8 running");
    wait_drain();
    run = 1'b0;
    push_exp(3'b110, 2, "R8 high half completes");
    push_exp(3'b000, 3, "R8 stopped");
    wait_drain();

    // R8 via gate during a high half
    @(negedge clk);
    rate_code = 3'd1; run = 1'b1;
    push_exp(3'b010, 2, "R8 gate run");
    push_exp(3'b110, 1, "R8 gate run");
    wait_drain();
    gate = 1'b1;
    push_exp(3'b110, 1, "R8 gate high completes");
    push_exp(3'b000, 3, "R8 gate stopped");
    wait_drain();
    gate = 1'b0; run = 1'b0;

    repeat (2) @(negedge clk);
    report();
  end

endmodule